// File: doc/BRIEF.md
# Paired-Byte Saturating Event Counter

This block keeps a 16-bit tally of single-cycle event pulses, such as line code violations or framing errors, and lets a host with an 8-bit data path fetch it as two bytes. The first byte access of a pair freezes the tally. Both bytes therefore come from the same value, even when events keep arriving between the two accesses. Events that arrive while the tally is frozen are discarded. Completing the pair by reading the opposite byte returns that byte and clears the tally to zero. The tally stops at 0xFFFF and stays there until a completed pair read clears it.

The host interface has no flow control. A read strobe is accepted in the cycle it is high, and the design never stalls the host. The selected byte appears on the read data port one clock later and stays there until the next strobe. Event detection, channel address decoding and bus timing belong to the surrounding logic.

Top module: `pcr_pair_counter`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the tally is zero, no pair is open, and `rdata_o` is 0x00.
- R2: With no pair open and no strobe, each clock with `evt_i` high raises the tally by exactly one.
- R3: A strobe on `rd_i` with `sel_hi_i` = 0 puts tally bits 7:0 on `rdata_o`, and with `sel_hi_i` = 1 puts bits 15:8. The byte appears one clock after the strobe and holds until the next strobe.
- R4: The first strobe of a pair freezes the tally. Events in that strobe's cycle, and in every cycle up to and including the completing strobe, are discarded.
- R5: A strobe for the byte opposite to the one that opened the pair returns that byte from the frozen value, then clears the tally to zero and closes the pair.
- R6: A pair may be opened with the high byte (`sel_hi_i` = 1) and completed with the low byte, with the same result as low-then-high.
- R7: A second strobe for the same byte that opened the pair returns that byte again, keeps the tally frozen and clears nothing.
- R8: At 0xFFFF the tally ignores further events. Counting starts again from zero after a completed pair read.
- R9: An event in the same cycle as the completing strobe is lost. The tally after that cycle is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 1 | One event per cycle while high |
| rd_i | input | 1 | Byte read strobe, one access per cycle |
| sel_hi_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| rdata_o | output | 8 | Byte returned by the last strobe |

## Verification
An event pulse can land in the same cycle as a read strobe, and it can do so at either end of a pair. The bench raises `evt_i` together with the opening strobe and together with the completing strobe. It then reads a fresh pair and expects zero, which shows that neither event was counted and that the clear took effect. Events are also injected between the two strobes and during a repeated same-byte strobe. The bench judges these by the byte values returned and by a follow-up pair that must read zero.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic {
    PCR_SEL_LO = 1'b0,
    PCR_SEL_HI = 1'b1
  } pcr_sel_e;
endpackage

// File: rtl/pcr_pair_ctl.sv
module pcr_pair_ctl
  import pcr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_i,
  input  pcr_sel_e sel_i,
  output logic     frz_o,
  output logic     hold_o,
  output logic     clr_o,
  output pcr_sel_e first_o
);
  logic     open_q;
  pcr_sel_e first_q;

  // completing access: pair open and the other byte is requested
  assign clr_o   = rd_i && open_q && (sel_i != first_q);
  // counting halts from the opening strobe through the completing one
  assign hold_o  = rd_i || open_q;
  assign frz_o   = open_q;
  assign first_o = first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      first_q <= PCR_SEL_LO;
    end else if (rd_i) begin
      if (!open_q) begin
        open_q  <= 1'b1;
        first_q <= sel_i;
      end else if (sel_i != first_q) begin
        open_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcr_sat_cnt.sv
module pcr_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         hold_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;
  logic         full;

  assign full  = (cnt_q == TOP);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !hold_i && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcr_byte_rd.sv
module pcr_byte_rd #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  localparam int SELW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int WW    = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic [WW-1:0]     word_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] lane [NB];
  logic [BYTE_W-1:0] data_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (rd_i) begin
      data_q <= lane[sel_i];
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/pcr_pair_counter.sv
module pcr_pair_counter
  import pcr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              rd_i,
  input  logic              sel_hi_i,
  output logic [BYTE_W-1:0] rdata_o
);
  pcr_sel_e    sel_e;
  pcr_sel_e    first_e;
  logic        frz_w;
  logic        hold_w;
  logic        clr_w;
  logic        first_w;
  logic [CW-1:0] cnt_w;

  assign sel_e   = sel_hi_i ? PCR_SEL_HI : PCR_SEL_LO;
  assign first_w = (first_e == PCR_SEL_HI);

  pcr_pair_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_i),
    .sel_i   (sel_e),
    .frz_o   (frz_w),
    .hold_o  (hold_w),
    .clr_o   (clr_w),
    .first_o (first_e)
  );

  pcr_sat_cnt #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (evt_i),
    .hold_i (hold_w),
    .clr_i  (clr_w),
    .cnt_o  (cnt_w)
  );

  pcr_byte_rd #(.BYTE_W(BYTE_W), .NB(2)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (rd_i),
    .sel_i  (sel_hi_i),
    .word_i (cnt_w),
    .data_o (rdata_o)
  );
endmodule

// File: rtl/pcr_pair_counter_chk.sv
module pcr_pair_counter_chk #(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_i,
  input logic              rd_i,
  input logic              sel_hi_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [CW-1:0]     cnt,
  input logic              frz,
  input logic              first
);
  logic done;
  assign done = rd_i && frz && (sel_hi_i != first);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !frz && rdata_o == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !rd_i && !frz && cnt != {CW{1'b1}}) |=> cnt == $past(cnt) + 1'b1);

  // R3
  byte_select_chk: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rdata_o == ($past(sel_hi_i) ? $past(cnt[CW-1:BYTE_W]) : $past(cnt[BYTE_W-1:0])));

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || frz) && !done) |=> cnt == $past(cnt));

  // R5
  pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt == '0 && !frz));

  // R7
  repeat_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && frz && sel_hi_i == first) |=> frz);

  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CW{1'b1}} && !done) |=> cnt == {CW{1'b1}});
endmodule

bind pcr_pair_counter pcr_pair_counter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_i    (evt_i),
  .rd_i     (rd_i),
  .sel_hi_i (sel_hi_i),
  .rdata_o  (rdata_o),
  .cnt      (cnt_w),
  .frz      (frz_w),
  .first    (first_w)
);

// File: tb/sim_pcr_pair_counter.sv
`timescale 1ns/1ps
module sim_pcr_pair_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt = 1'b0;
  logic       rd  = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] rdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pcr_pair_counter u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .rd_i(rd), .sel_hi_i(sel), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic add_ev(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = 1'b1;
    end
    @(negedge clk); evt = 1'b0;
  endtask

  task automatic do_rd(input logic s, input logic e, output logic [7:0] v);
    @(negedge clk); rd = 1'b1; sel = s; evt = e;
    @(negedge clk); rd = 1'b0; evt = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata after reset", rdata, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R1 low byte", v, 8'h00);
    do_rd(1'b1, 1'b0, v); check("R1 high byte", v, 8'h00);
  endtask

  task automatic t_count();
    logic [7:0] v;
    add_ev(5);
    do_rd(1'b0, 1'b0, v); check("R2 R3 low of 5", v, 8'h05);
    do_rd(1'b1, 1'b0, v); check("R3 high of 5", v, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R5 cleared low", v, 8'h00);
    do_rd(1'b1, 1'b0, v); check("R5 cleared high", v, 8'h00);
  endtask

  task automatic t_freeze();
    logic [7:0] v;
    add_ev(300);
    do_rd(1'b0, 1'b0, v); check("R3 low of 0x012C", v, 8'h2C);
    add_ev(10);
    do_rd(1'b1, 1'b0, v); check("R4 high frozen", v, 8'h01);
    check("R3 data held", rdata, 8'h01);
    do_rd(1'b0, 1'b0, v); check("R4 R5 dropped low", v, 8'h00);
    do_rd(1'b1, 1'b0, v); check("R4 R5 dropped high", v, 8'h00);
  endtask

  task automatic t_hi_first();
    logic [7:0] v;
    add_ev(515);
    do_rd(1'b1, 1'b0, v); check("R6 high first", v, 8'h02);
    do_rd(1'b0, 1'b0, v); check("R6 low second", v, 8'h03);
    do_rd(1'b1, 1'b0, v); check("R6 cleared high", v, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R6 cleared low", v, 8'h00);
  endtask

  task automatic t_repeat();
    logic [7:0] v;
    add_ev(7);
    do_rd(1'b0, 1'b0, v); check("R7 first low", v, 8'h07);
    add_ev(3);
    do_rd(1'b0, 1'b0, v); check("R7 repeat low", v, 8'h07);
    do_rd(1'b1, 1'b0, v); check("R7 high", v, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R7 cleared low", v, 8'h00);
    do_rd(1'b1, 1'b0, v); check("R7 cleared high", v, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    add_ev(4);
    do_rd(1'b0, 1'b1, v); check("R4 event with opening read", v, 8'h04);
    do_rd(1'b1, 1'b1, v); check("R9 event with closing read", v, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R9 zero after low", v, 8'h00);
    do_rd(1'b1, 1'b0, v); check("R9 zero after high", v, 8'h00);
    add_ev(1);
    do_rd(1'b0, 1'b0, v); check("R2 resumes", v, 8'h01);
    do_rd(1'b1, 1'b0, v); check("R2 resumes high", v, 8'h00);
  endtask

  task automatic t_sat();
    logic [7:0] v;
    add_ev(65540);
    do_rd(1'b0, 1'b0, v); check("R8 sat low", v, 8'hFF);
    do_rd(1'b1, 1'b0, v); check("R8 sat high", v, 8'hFF);
    add_ev(2);
    do_rd(1'b1, 1'b0, v); check("R8 restart high", v, 8'h00);
    do_rd(1'b0, 1'b0, v); check("R8 restart low", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_freeze();
    t_hi_first();
    t_repeat();
    t_same_cycle();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule